// File: doc/BRIEF.md
# Shared Interrupt Distributor Register File

This block holds the per-line interrupt state for the shared interrupt lines, which are numbered from 32 upward and grouped into banks of 32. For each line it keeps pending, active, enable, group and trigger-configuration bits, an 8-bit priority field, and a 64-bit route word. Software reaches this state through a single memory-mapped port that carries 32-bit and 64-bit accesses. Peripheral sources drive the pending bits through a sideband input that carries a line number and a level.

The boot core claims interrupts through an acknowledge handshake and releases them through an end-of-interrupt input. The acknowledge handshake returns the chosen line number, or 1023 when no line is waiting. End-of-interrupt numbers below 32 belong to the per-core block, so this block passes them straight on. Bank 0 holds the per-core lines. In this block it is reserved: it reads as zero and ignores writes.

The block does not arbitrate by priority or route by affinity. It only stores the priority and route values.

Top module: `shared_irq_regfile`

## Requirements
- R1: After a synchronous active-low reset, all state is zero. `irq`, `ack_valid`, `fwd_eoi_valid` and `rsp_valid` are low, and the control word reads 0x50.
- R2: A 32-bit write to set-enable (0x100 + 4*bank) ORs the data into that bank's enable word. A write to clear-enable (0x180 + 4*bank) clears the bits that are 1 in the data. Reads at either address return the enable word.
- R3: Set-active (0x300 + 4*bank) and clear-active (0x380 + 4*bank) act on the active word in the same OR / AND-NOT way, and both read it back. The pending word reads raw at 0x200 + 4*bank and at 0x280 + 4*bank, and bus writes to either pending address change nothing.
- R4: The following writes are ignored, and these locations read zero:
  - bank 0 of the group, enable and active words;
  - configuration words 0 and 1;
  - priority words 0 to 7.
- R5: A write to configuration word w (0xC00 + 4*w, w >= 2) stores the data ANDed with 0xAAAAAAAA.
- R6: A write to priority word w (0x400 + 4*w, w >= 8) stores the full 32-bit data, and it reads back unchanged. Group words (0x080 + 4*bank) also store their data whole.
- R7: Route words sit at 0x6000 + 8*id. They accept only 64-bit accesses, and writes for ids below 32 are ignored. A 32-bit access in the route region reads zero and writes nothing.
- R8: An acknowledge takes the lowest bank that has a bit set in pending AND NOT active, and in that bank the most significant such bit. It clears that pending bit, sets that active bit, and one cycle later presents `ack_valid` with id = bank*32 + bit. The enable bits play no part in this choice.
- R9: If no line is pending and not active, the acknowledge returns 1023 and changes no state.
- R10: End-of-interrupt with an id of 32 or more clears that id's active bit. An id below 32 leaves the state alone and appears one cycle later on `fwd_eoi_valid` / `fwd_eoi_id`.
- R11: `irq` is high exactly when some line is pending, not active and enabled.
- R12: The control word at 0x000 has the following bits:
  - bits 0 and 1 hold the two group enables and read back what was written;
  - bits 4 and 6 always read as 1.

  The type word at 0x004 reads 0x0028001F: the line-count field in bits 4:0 is 31 and the id-bits field in bits 23:19 is 5. The implementer word at 0x008 reads 0, and the ID2 word at 0xFFE8 reads 0x30.
- R13: An access whose address is not aligned to its size (4 or 8 bytes) is dropped. A misaligned read returns all ones: 64 bits for a wide read, or the low 32 bits for a narrow read. A read of an unmapped address returns 0. Read data appears on `rsp_rdata` with `rsp_valid` one cycle after the request.
- R14: A sideband pulse sets or clears the pending bit of `pend_id` to `pend_level` at the next clock edge. Ids below 32 and ids beyond the last bank are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | 16 | Byte offset of the access |
| req_wdata | input | 64 | Write data (low 32 bits for narrow accesses) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data |
| pend_valid | input | 1 | Sideband pending update strobe |
| pend_id | input | 10 | Line whose pending bit is updated |
| pend_level | input | 1 | New pending value |
| ack_req | input | 1 | Acknowledge request from the boot core |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Acknowledged line, or 1023 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | Line being completed |
| fwd_eoi_valid | output | 1 | Forwarded end-of-interrupt for a per-core line |
| fwd_eoi_id | output | 5 | Forwarded per-core line number |
| irq | output | 1 | Interrupt request to the boot core |

## Verification
The assertions assume the following about the inputs:
- Each control input is a single-cycle pulse.
- A bus write to the active words does not target the same line as an end-of-interrupt or an acknowledge in the same cycle.
- `ack_req` is not raised again before the previous result has been observed.

The stimulus drives every request for exactly one cycle, on the falling edge, and leaves idle cycles between requests. No sideband, bus, acknowledge or end-of-interrupt event overlaps another, so each checked outcome has a single cause.

// File: rtl/shirq_pkg.sv
// Package: shared constants and types for the shared interrupt register file.
// Assumes a 16-bit byte address space and 32 lines per bank.
package shirq_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 64;
    localparam int LINE_W    = 32;
    localparam int ID_W      = 10;
    localparam int WIDX_W    = 10;
    localparam int FIRST_SHARED = 32;
    localparam logic [ID_W-1:0] NONE_ID = 10'd1023;
    localparam logic [31:0] CFG_KEEP = 32'hAAAA_AAAA;

    typedef enum logic [3:0] {
        K_NONE, K_CTRL, K_TYPE, K_IMPL, K_ID2,
        K_GROUP, K_SETEN, K_CLREN, K_SETPEND, K_CLRPEND,
        K_SETACT, K_CLRACT, K_PRIO, K_CFG, K_ROUTE
    } reg_kind_e;

endpackage

// File: rtl/shirq_addr_decode.sv
// Module: classifies a register access by region, word index and alignment.
// Assumes a fixed 16-bit map. Route words are reachable only by wide accesses,
// every other word only by narrow ones.
module shirq_addr_decode
    import shirq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output reg_kind_e         kind,
    output logic [WIDX_W-1:0] idx,
    output logic              misaligned
);

    // Purpose: flag accesses not aligned to their own size.
    always_comb begin
        misaligned = wide ? (addr[2:0] != 3'd0) : (addr[1:0] != 2'd0);
    end

    // Purpose: map an aligned address onto a register region and index.
    always_comb begin
        kind = K_NONE;
        idx  = '0;
        if (!misaligned) begin
            if (wide) begin
                if (addr[15:13] == 3'b011) begin
                    kind = K_ROUTE;
                    idx  = addr[12:3];
                end
            end else if (addr == 16'h0000) begin
                kind = K_CTRL;
            end else if (addr == 16'h0004) begin
                kind = K_TYPE;
            end else if (addr == 16'h0008) begin
                kind = K_IMPL;
            end else if (addr == 16'hFFE8) begin
                kind = K_ID2;
            end else if (addr[15:10] == 6'd1) begin
                kind = K_PRIO;
                idx  = WIDX_W'(addr[9:2]);
            end else if (addr[15:8] == 8'h0C) begin
                kind = K_CFG;
                idx  = WIDX_W'(addr[7:2]);
            end else begin
                idx = WIDX_W'(addr[6:2]);
                case (addr[15:7])
                    9'd1:    kind = K_GROUP;
                    9'd2:    kind = K_SETEN;
                    9'd3:    kind = K_CLREN;
                    9'd4:    kind = K_SETPEND;
                    9'd5:    kind = K_CLRPEND;
                    9'd6:    kind = K_SETACT;
                    9'd7:    kind = K_CLRACT;
                    default: kind = K_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/shirq_ack_pick.sv
// Module: chooses the line an acknowledge would claim.
// The lowest bank with a pending-not-active bit wins, and inside it the highest bit.
// Assumes bank 0 inputs are zero when that bank is reserved.
module shirq_ack_pick
    import shirq_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS*LINE_W-1:0] pend,
    input  logic [NUM_BANKS*LINE_W-1:0] act,
    output logic                        found,
    output logic [ID_W-1:0]             id
);

    logic [LINE_W-1:0] cand;

    // Purpose: scan banks from the top down so that the lowest hit is kept.
    always_comb begin
        found = 1'b0;
        id    = NONE_ID;
        cand  = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            cand = pend[b*LINE_W +: LINE_W] & ~act[b*LINE_W +: LINE_W];
            if (cand != '0) begin
                found = 1'b1;
                for (int i = 0; i < LINE_W; i++) begin
                    if (cand[i]) id = ID_W'(b * LINE_W + i);
                end
            end
        end
    end

endmodule

// File: rtl/shirq_route_store.sv
// Module: holds one 64-bit route word per line.
// Words for the per-core ids below 32 are absent and read zero.
// Assumes that writes arrive already decoded and aligned.
module shirq_route_store
    import shirq_pkg::*;
#(
    parameter int NUM_IDS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [NUM_IDS*DATA_W-1:0] words;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_word
        if (g < FIRST_SHARED) begin : g_resv
            assign words[g*DATA_W +: DATA_W] = '0;
        end else begin : g_live
            logic [DATA_W-1:0] w_q;
            // Purpose: capture a wide write aimed at this id.
            always_ff @(posedge clk) begin
                if (!rst_n)                               w_q <= '0;
                else if (wr_en && idx == WIDX_W'(g))      w_q <= wdata;
            end
            assign words[g*DATA_W +: DATA_W] = w_q;
        end
    end

    // Purpose: select the addressed word; out-of-range indices read zero.
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_IDS; g++) begin
            if (idx == WIDX_W'(g)) rdata = words[g*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/shared_irq_regfile.sv
// Module: top-level register file for the shared interrupt lines.
// It holds per-bank pending/active/enable/group state, configuration and priority
// words, and route words. It serves a 32/64-bit register port and a sideband
// pending input, and runs acknowledge and end-of-interrupt for the boot core.
// Assumes: bank 0 is owned by the per-core block, and control inputs are pulses.
module shared_irq_regfile
    import shirq_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              pend_valid,
    input  logic [ID_W-1:0]   pend_id,
    input  logic              pend_level,
    input  logic              ack_req,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    input  logic              eoi_valid,
    input  logic [ID_W-1:0]   eoi_id,
    output logic              fwd_eoi_valid,
    output logic [4:0]        fwd_eoi_id,
    output logic              irq
);

    localparam int NUM_IDS    = NUM_BANKS * LINE_W;
    localparam int CFG_WORDS  = NUM_BANKS * 2;
    localparam int PRIO_WORDS = NUM_BANKS * 8;
    localparam int IDX_W      = $clog2(NUM_IDS);
    localparam logic [ID_W-1:0] FIRST_ID = ID_W'(FIRST_SHARED);
    localparam logic [ID_W-1:0] ID_LIM   = ID_W'(NUM_IDS);

    reg_kind_e         dec_kind;
    logic [WIDX_W-1:0] dec_idx;
    logic              dec_misal;
    logic              wr_ok;
    logic              rd_fire;
    logic [31:0]       wd;

    logic [NUM_IDS-1:0] pend_flat, act_flat, en_flat, grp_flat;
    logic [CFG_WORDS*32-1:0]  cfg_flat;
    logic [PRIO_WORDS*32-1:0] prio_flat;
    logic [DATA_W-1:0] route_rd;
    logic              pick_found;
    logic [ID_W-1:0]   pick_id;
    logic              grp0_q, grp1_q;
    logic [DATA_W-1:0] rd_data;

    assign wr_ok   = req_valid && req_write && !dec_misal;
    assign rd_fire = req_valid && !req_write;
    assign wd      = req_wdata[31:0];

    shirq_addr_decode u_dec (
        .addr       (req_addr),
        .wide       (req_wide),
        .kind       (dec_kind),
        .idx        (dec_idx),
        .misaligned (dec_misal)
    );

    shirq_ack_pick #(.NUM_BANKS(NUM_BANKS)) u_pick (
        .pend  (pend_flat),
        .act   (act_flat),
        .found (pick_found),
        .id    (pick_id)
    );

    shirq_route_store #(.NUM_IDS(NUM_IDS)) u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_ok && dec_kind == K_ROUTE),
        .idx   (dec_idx),
        .wdata (req_wdata),
        .rdata (route_rd)
    );

    // Per-bank line state; bank 0 is reserved and reads zero.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (b == 0) begin : g_resv
            assign pend_flat[b*LINE_W +: LINE_W] = '0;
            assign act_flat [b*LINE_W +: LINE_W] = '0;
            assign en_flat  [b*LINE_W +: LINE_W] = '0;
            assign grp_flat [b*LINE_W +: LINE_W] = '0;
        end else begin : g_live
            logic [31:0] pend_r, act_r, en_r, grp_r;
            logic [31:0] pend_nx, act_nx, en_nx;
            logic        hit_bank, ack_here, eoi_here, side_here;

            assign hit_bank  = (dec_idx == WIDX_W'(b));
            assign ack_here  = ack_req && pick_found && pick_id[ID_W-1:5] == 5'(b);
            assign eoi_here  = eoi_valid && eoi_id[ID_W-1:5] == 5'(b);
            assign side_here = pend_valid && pend_id[ID_W-1:5] == 5'(b);

            // Purpose: next-state for enable, active and pending of this bank.
            always_comb begin
                en_nx = en_r;
                if (wr_ok && hit_bank && dec_kind == K_SETEN) en_nx = en_nx | wd;
                if (wr_ok && hit_bank && dec_kind == K_CLREN) en_nx = en_nx & ~wd;
                act_nx = act_r;
                if (wr_ok && hit_bank && dec_kind == K_SETACT) act_nx = act_nx | wd;
                if (wr_ok && hit_bank && dec_kind == K_CLRACT) act_nx = act_nx & ~wd;
                if (eoi_here) act_nx[eoi_id[4:0]] = 1'b0;
                if (ack_here) act_nx[pick_id[4:0]] = 1'b1;
                pend_nx = pend_r;
                if (ack_here)  pend_nx[pick_id[4:0]] = 1'b0;
                if (side_here) pend_nx[pend_id[4:0]] = pend_level;
            end

            // Purpose: register the bank state.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_r <= '0;
                    act_r  <= '0;
                    en_r   <= '0;
                    grp_r  <= '0;
                end else begin
                    pend_r <= pend_nx;
                    act_r  <= act_nx;
                    en_r   <= en_nx;
                    if (wr_ok && hit_bank && dec_kind == K_GROUP) grp_r <= wd;
                end
            end

            assign pend_flat[b*LINE_W +: LINE_W] = pend_r;
            assign act_flat [b*LINE_W +: LINE_W] = act_r;
            assign en_flat  [b*LINE_W +: LINE_W] = en_r;
            assign grp_flat [b*LINE_W +: LINE_W] = grp_r;
        end
    end

    // Trigger-configuration words; the first two belong to the per-core block.
    for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
        if (w < 2) begin : g_resv
            assign cfg_flat[w*32 +: 32] = '0;
        end else begin : g_live
            logic [31:0] c_q;
            // Purpose: keep only the edge/level bit of each 2-bit field.
            always_ff @(posedge clk) begin
                if (!rst_n) c_q <= '0;
                else if (wr_ok && dec_kind == K_CFG && dec_idx == WIDX_W'(w))
                    c_q <= wd & CFG_KEEP;
            end
            assign cfg_flat[w*32 +: 32] = c_q;
        end
    end

    // Priority words; the first eight belong to the per-core block.
    for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prio
        if (w < 8) begin : g_resv
            assign prio_flat[w*32 +: 32] = '0;
        end else begin : g_live
            logic [31:0] p_q;
            // Purpose: store four priority bytes as written.
            always_ff @(posedge clk) begin
                if (!rst_n) p_q <= '0;
                else if (wr_ok && dec_kind == K_PRIO && dec_idx == WIDX_W'(w))
                    p_q <= wd;
            end
            assign prio_flat[w*32 +: 32] = p_q;
        end
    end

    // Purpose: hold the two group-enable bits of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp0_q <= 1'b0;
            grp1_q <= 1'b0;
        end else if (wr_ok && dec_kind == K_CTRL) begin
            grp0_q <= wd[0];
            grp1_q <= wd[1];
        end
    end

    // Purpose: form read data for the addressed register.
    always_comb begin
        rd_data = '0;
        if (dec_misal) begin
            rd_data = req_wide ? '1 : {32'h0, 32'hFFFF_FFFF};
        end else begin
            case (dec_kind)
                K_CTRL:  rd_data = {56'h0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, grp1_q, grp0_q};
                K_TYPE:  rd_data = 64'h0000_0000_0028_001F;
                K_ID2:   rd_data = 64'h30;
                K_ROUTE: rd_data = route_rd;
                default: rd_data = '0;
            endcase
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (dec_idx == WIDX_W'(b)) begin
                    case (dec_kind)
                        K_GROUP:             rd_data = {32'h0, grp_flat[b*LINE_W +: LINE_W]};
                        K_SETEN, K_CLREN:    rd_data = {32'h0, en_flat[b*LINE_W +: LINE_W]};
                        K_SETACT, K_CLRACT:  rd_data = {32'h0, act_flat[b*LINE_W +: LINE_W]};
                        K_SETPEND, K_CLRPEND: rd_data = {32'h0, pend_flat[b*LINE_W +: LINE_W]};
                        default: ;
                    endcase
                end
            end
            for (int w = 0; w < CFG_WORDS; w++) begin
                if (dec_kind == K_CFG && dec_idx == WIDX_W'(w))
                    rd_data = {32'h0, cfg_flat[w*32 +: 32]};
            end
            for (int w = 0; w < PRIO_WORDS; w++) begin
                if (dec_kind == K_PRIO && dec_idx == WIDX_W'(w))
                    rd_data = {32'h0, prio_flat[w*32 +: 32]};
            end
        end
    end

    // Purpose: register read response, acknowledge result and forwarded EOI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            ack_valid     <= 1'b0;
            ack_id        <= NONE_ID;
            fwd_eoi_valid <= 1'b0;
            fwd_eoi_id    <= '0;
        end else begin
            rsp_valid     <= rd_fire;
            if (rd_fire) rsp_rdata <= rd_data;
            ack_valid     <= ack_req;
            if (ack_req) ack_id <= pick_found ? pick_id : NONE_ID;
            fwd_eoi_valid <= eoi_valid && eoi_id < FIRST_ID;
            if (eoi_valid && eoi_id < FIRST_ID) fwd_eoi_id <= eoi_id[4:0];
        end
    end

    // Purpose: request when any line is pending, not active and enabled.
    always_comb begin
        irq = |(pend_flat & ~act_flat & en_flat);
    end

    // A claimed line must be active when its id is presented.
    assert_ack_sets_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && ack_id != NONE_ID |-> act_flat[ack_id[IDX_W-1:0]]);

    // With nothing claimable, the result must be the empty code.
    assert_ack_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && !pick_found |=> ack_valid && ack_id == NONE_ID);

    // Per-core completions are forwarded with their number.
    assert_eoi_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid && eoi_id < FIRST_ID |=> fwd_eoi_valid && fwd_eoi_id == $past(eoi_id[4:0]));

    // A sideband raise of a shared line is visible after one edge.
    assert_side_raise_R14: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid && pend_level && pend_id >= FIRST_ID && pend_id < ID_LIM
        |=> pend_flat[$past(pend_id[IDX_W-1:0])]);

    // A misaligned wide read returns all ones.
    assert_misaligned_ones_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire && dec_misal && req_wide |=> rsp_valid && rsp_rdata == '1);

endmodule

// File: tb/shared_irq_regfile_tb.sv
module shared_irq_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        pend_valid = 1'b0, pend_level = 1'b0;
    logic [9:0]  pend_id = '0;
    logic        ack_req = 1'b0;
    logic        ack_valid;
    logic [9:0]  ack_id;
    logic        eoi_valid = 1'b0;
    logic [9:0]  eoi_id = '0;
    logic        fwd_eoi_valid;
    logic [4:0]  fwd_eoi_id;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    shared_irq_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pend_valid(pend_valid), .pend_id(pend_id), .pend_level(pend_level),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .fwd_eoi_valid(fwd_eoi_valid), .fwd_eoi_id(fwd_eoi_id),
        .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [15:0] addr;
        logic [63:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 45;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 64'h50,                  8'd12}, // R12 control after reset
        '{1'b1, 1'b0, 16'h0000, 64'hFFFF_FFFF,           8'd12},
        '{1'b0, 1'b0, 16'h0000, 64'h53,                  8'd12},
        '{1'b0, 1'b0, 16'h0004, 64'h0028_001F,           8'd12},
        '{1'b0, 1'b0, 16'hFFE8, 64'h30,                  8'd12},
        '{1'b0, 1'b0, 16'h0008, 64'h0,                   8'd12},
        '{1'b1, 1'b0, 16'h0104, 64'h0000_00F0,           8'd2},  // R2 set enable
        '{1'b1, 1'b0, 16'h0104, 64'h0000_0F00,           8'd2},
        '{1'b0, 1'b0, 16'h0184, 64'h0000_0FF0,           8'd2},
        '{1'b1, 1'b0, 16'h0184, 64'h0000_0330,           8'd2},
        '{1'b0, 1'b0, 16'h0104, 64'h0000_0CC0,           8'd2},
        '{1'b1, 1'b0, 16'h0100, 64'hFFFF_FFFF,           8'd4},  // R4 bank 0
        '{1'b0, 1'b0, 16'h0100, 64'h0,                   8'd4},
        '{1'b1, 1'b0, 16'h0080, 64'hFFFF_FFFF,           8'd4},
        '{1'b0, 1'b0, 16'h0080, 64'h0,                   8'd4},
        '{1'b1, 1'b0, 16'h0088, 64'h1234_5678,           8'd6},  // R6 group word
        '{1'b0, 1'b0, 16'h0088, 64'h1234_5678,           8'd6},
        '{1'b1, 1'b0, 16'h0C08, 64'hFFFF_FFFF,           8'd5},  // R5 config mask
        '{1'b0, 1'b0, 16'h0C08, 64'hAAAA_AAAA,           8'd5},
        '{1'b1, 1'b0, 16'h0C04, 64'hFFFF_FFFF,           8'd4},
        '{1'b0, 1'b0, 16'h0C04, 64'h0,                   8'd4},
        '{1'b1, 1'b0, 16'h0420, 64'hA0B0_C0D0,           8'd6},  // R6 priority
        '{1'b0, 1'b0, 16'h0420, 64'hA0B0_C0D0,           8'd6},
        '{1'b1, 1'b0, 16'h0400, 64'hFFFF_FFFF,           8'd4},
        '{1'b0, 1'b0, 16'h0400, 64'h0,                   8'd4},
        '{1'b1, 1'b1, 16'h6100, 64'h1122_3344_5566_7788, 8'd7},  // R7 route id 32
        '{1'b0, 1'b1, 16'h6100, 64'h1122_3344_5566_7788, 8'd7},
        '{1'b1, 1'b1, 16'h6008, ONES,                    8'd7},
        '{1'b0, 1'b1, 16'h6008, 64'h0,                   8'd7},
        '{1'b0, 1'b0, 16'h6100, 64'h0,                   8'd7},
        '{1'b1, 1'b0, 16'h6108, 64'hFFFF_FFFF,           8'd7},
        '{1'b0, 1'b1, 16'h6108, 64'h0,                   8'd7},
        '{1'b1, 1'b0, 16'h0106, 64'hFFFF_FFFF,           8'd13}, // R13 misaligned
        '{1'b0, 1'b0, 16'h0104, 64'h0000_0CC0,           8'd13},
        '{1'b0, 1'b0, 16'h0102, 64'hFFFF_FFFF,           8'd13},
        '{1'b0, 1'b1, 16'h6104, ONES,                    8'd13},
        '{1'b0, 1'b0, 16'h0E00, 64'h0,                   8'd13},
        '{1'b1, 1'b0, 16'h0304, 64'h5,                   8'd3},  // R3 active
        '{1'b0, 1'b0, 16'h0384, 64'h5,                   8'd3},
        '{1'b1, 1'b0, 16'h0384, 64'h1,                   8'd3},
        '{1'b0, 1'b0, 16'h0304, 64'h4,                   8'd3},
        '{1'b1, 1'b0, 16'h0204, 64'hFFFF_FFFF,           8'd3},
        '{1'b0, 1'b0, 16'h0284, 64'h0,                   8'd3},
        '{1'b1, 1'b0, 16'h0384, 64'hFFFF_FFFF,           8'd3},
        '{1'b1, 1'b0, 16'h0184, 64'hFFFF_FFFF,           8'd2}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic wide, input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = wide; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic wide, input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_valid ? rsp_rdata : 64'hDEAD;
    endtask

    task automatic side(input logic [9:0] id, input logic lvl);
        @(negedge clk);
        pend_valid = 1'b1; pend_id = id; pend_level = lvl;
        @(negedge clk);
        pend_valid = 1'b0;
    endtask

    task automatic do_ack(input logic [9:0] exp, input string tag);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        check({tag, " ack valid"}, 64'(ack_valid), 64'd1);
        check({tag, " ack id"}, 64'(ack_id), 64'(exp));
    endtask

    task automatic do_eoi(input logic [9:0] id);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = id;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of outputs and pending words
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 ack_valid", 64'(ack_valid), 64'd0);
        check("R1 fwd_eoi_valid", 64'(fwd_eoi_valid), 64'd0);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        bus_read(1'b0, 16'h0204, r);
        check("R1 pending bank1", r, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].wide, VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].wide, VECS[i].addr, r);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].data);
            end
        end

        // R14 sideband pending
        side(10'd40, 1'b1);
        bus_read(1'b0, 16'h0204, r);
        check("R14 raise id 40", r, 64'h100);
        side(10'd5, 1'b1);
        bus_read(1'b0, 16'h0200, r);
        check("R14 per-core id ignored", r, 64'd0);
        side(10'd200, 1'b1);
        bus_read(1'b0, 16'h0204, r);
        check("R14 out-of-range id ignored", r, 64'h100);
        // R11 irq needs enable
        check("R11 irq without enable", 64'(irq), 64'd0);
        bus_write(1'b0, 16'h0104, 64'h100);
        check("R11 irq with enable", 64'(irq), 64'd1);

        // R8 acknowledge order
        side(10'd70, 1'b1);
        side(10'd45, 1'b1);
        side(10'd33, 1'b1);
        do_ack(10'd45, "R8 first");
        bus_read(1'b0, 16'h0304, r);
        check("R8 active after ack", r, 64'h2000);
        bus_read(1'b0, 16'h0204, r);
        check("R8 pending after ack", r, 64'h102);
        do_ack(10'd40, "R8 second");
        do_ack(10'd33, "R8 third");
        do_ack(10'd70, "R8 next bank");
        do_ack(10'd1023, "R9 empty");
        bus_read(1'b0, 16'h0304, r);
        check("R9 state unchanged", r, 64'h2102);
        check("R11 irq all active", 64'(irq), 64'd0);

        // R10 end of interrupt
        do_eoi(10'd45);
        bus_read(1'b0, 16'h0304, r);
        check("R10 eoi clears active", r, 64'h0102);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = 10'd3;
        @(negedge clk);
        eoi_valid = 1'b0;
        check("R10 forward valid", 64'(fwd_eoi_valid), 64'd1);
        check("R10 forward id", 64'(fwd_eoi_id), 64'd3);
        bus_read(1'b0, 16'h0304, r);
        check("R10 per-core eoi leaves state", r, 64'h0102);
        do_eoi(10'd40);
        side(10'd40, 1'b1);
        check("R11 irq after re-raise", 64'(irq), 64'd1);

        // R14 clear by level 0
        side(10'd50, 1'b1);
        bus_read(1'b0, 16'h0204, r);
        check("R14 raise id 50", r, 64'h4_0100);
        side(10'd50, 1'b0);
        bus_read(1'b0, 16'h0204, r);
        check("R14 clear id 50", r, 64'h100);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 64'(irq), 64'd0);
        bus_read(1'b0, 16'h0104, r);
        check("R1 enable after reset", r, 64'd0);
        bus_read(1'b0, 16'h0000, r);
        check("R1 control after reset", r, 64'h50);
        bus_read(1'b1, 16'h6100, r);
        check("R1 route after reset", r, 64'd0);

        done = 1'b1;
        finish_run();
    end

endmodule